// File: doc/BRIEF.md
# Serial Three-Wire Configuration Port with Addressed Latches

This block receives configuration words for a frequency synthesizer over three slow wires: a serial clock, a serial data line and a latch-enable strobe. All three are brought into the system clock domain through synchronizers. Each rising edge of the serial clock shifts one data bit into a 21-bit word register, most significant bit first. Nothing downstream sees the bits while they arrive.

When latch enable rises, the two lowest bits of the word choose one of three holding latches. These are the reference-divider latch, the A/B counter latch and the function latch. The rest of the word is copied into the chosen latch in a single system cycle. The fourth address code is reserved, and a word carrying it changes nothing. The latch contents are presented as parallel outputs: the 14-bit reference divide value, the 5-bit A and 13-bit B counts, a charge-pump boost bit, a 3-bit output multiplexer select, and the control flags.

Top module: `cfg3w_port`

## Requirements
- R1: After a synchronous reset every latch output is zero.
- R2: The data line is sampled on each rising edge of the serial clock. The first bit shifted becomes word bit 20 and the last becomes word bit 0.
- R3: Only the 21 most recently shifted bits are kept. Bits shifted earlier than that have no effect on the loaded word.
- R4: Address bits [1:0] = 00 load the reference latch: ref_div = word[15:2].
- R5: Address bits [1:0] = 01 load the A/B latch: a_val = word[6:2], b_val = word[19:7], cp_boost = word[20]. Extreme values (A = 31, B = 8191) are carried unchanged.
- R6: Address bits [1:0] = 10 load the function latch: cnt_reset = word[2], pwr_down = word[3], mux_sel = word[6:4], pd_polarity = word[7], fastlock_en = word[8].
- R7: A word with address bits [1:0] = 11 leaves every output unchanged.
- R8: A load changes only the addressed latch. The other two latches keep their values.
- R9: No output changes while bits are being shifted. A latch changes only on a rising edge of latch enable, and latch enable held high causes only one load.
- R10: The loaded value appears at the outputs after the third system clock rising edge following the rise of latch enable, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch-enable strobe (asynchronous) |
| ref_div | output | 14 | Reference divide value |
| a_val | output | 5 | A counter value |
| b_val | output | 13 | B counter value |
| cp_boost | output | 1 | Charge-pump boost flag from the A/B latch |
| mux_sel | output | 3 | Output multiplexer select |
| pwr_down | output | 1 | Power-down flag |
| fastlock_en | output | 1 | Fastlock enable flag |
| cnt_reset | output | 1 | Counter reset flag |
| pd_polarity | output | 1 | Phase detector polarity |

## Verification
The assertions rely on each serial wire holding its level for at least three system clocks between transitions. They also rely on the data line being stable for those cycles before each serial clock rise, so that the synchronized data and clock are aligned. The stimulus meets both conditions by changing every pin on a falling system clock edge. It changes data only while the serial clock is low, and it keeps each serial phase and each latch-enable level for three or more system cycles.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int WORD_W = 21;
    localparam int ADDR_W = 2;
    localparam int REF_W  = 14;
    localparam int A_W    = 5;
    localparam int B_W    = 13;
    localparam int MUX_W  = 3;
    localparam int NUM_ADDR = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_REF  = 2'b00,
        ADDR_AB   = 2'b01,
        ADDR_FUNC = 2'b10,
        ADDR_RSVD = 2'b11
    } latch_addr_e;

    typedef struct packed {
        logic [REF_W-1:0] div;
    } ref_latch_t;

    typedef struct packed {
        logic           boost;
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } ab_latch_t;

    typedef struct packed {
        logic             fastlock_en;
        logic             pd_polarity;
        logic [MUX_W-1:0] mux_sel;
        logic             pwr_down;
        logic             cnt_reset;
    } fn_latch_t;

    localparam int REF_BITS = $bits(ref_latch_t);
    localparam int AB_BITS  = $bits(ab_latch_t);
    localparam int FN_BITS  = $bits(fn_latch_t);

    function automatic latch_addr_e word_addr(input logic [WORD_W-1:0] w);
        return latch_addr_e'(w[ADDR_W-1:0]);
    endfunction

    function automatic ref_latch_t unpack_ref(input logic [WORD_W-1:0] w);
        return ref_latch_t'(w[ADDR_W +: REF_BITS]);
    endfunction

    function automatic ab_latch_t unpack_ab(input logic [WORD_W-1:0] w);
        return ab_latch_t'(w[ADDR_W +: AB_BITS]);
    endfunction

    function automatic fn_latch_t unpack_fn(input logic [WORD_W-1:0] w);
        return fn_latch_t'(w[ADDR_W +: FN_BITS]);
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter
    import cfg3w_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= {sr[W-2:0], din};
    end

    assign word = sr;

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr)); // R9
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sr[W-1:1] == $past(sr[W-2:0])) && (sr[0] == $past(din))); // R2
endmodule

// File: rtl/cfg3w_latches.sv
module cfg3w_latches
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output ref_latch_t        ref_q,
    output ab_latch_t         ab_q,
    output fn_latch_t         fn_q
);
    logic [NUM_ADDR-1:0] strobe;

    genvar i;
    generate
        for (i = 0; i < NUM_ADDR; i++) begin : g_strobe
            assign strobe[i] = load && (word_addr(word) == latch_addr_e'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            ab_q  <= '0;
            fn_q  <= '0;
        end else begin
            if (strobe[ADDR_REF])  ref_q <= unpack_ref(word);
            if (strobe[ADDR_AB])   ab_q  <= unpack_ab(word);
            if (strobe[ADDR_FUNC]) fn_q  <= unpack_fn(word);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ref_q == '0) && (ab_q == '0) && (fn_q == '0)); // R1
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe)); // R8
    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ref_q) && $stable(ab_q) && $stable(fn_q)); // R9
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (load && word[ADDR_W-1:0] == 2'b11) |=> $stable(ref_q) && $stable(ab_q) && $stable(fn_q)); // R7
    AST_REF_ONLY: assert property (@(posedge clk) disable iff (rst)
        (load && word[ADDR_W-1:0] == 2'b00) |=> $stable(ab_q) && $stable(fn_q)); // R8
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_div,
    output logic [A_W-1:0]   a_val,
    output logic [B_W-1:0]   b_val,
    output logic             cp_boost,
    output logic [MUX_W-1:0] mux_sel,
    output logic             pwr_down,
    output logic             fastlock_en,
    output logic             cnt_reset,
    output logic             pd_polarity
);
    logic [2:0]        pins_sync;
    logic              sclk_s, sdat_s, sle_s;
    logic              sclk_d, sle_d;
    logic              sclk_rise, le_rise;
    logic [WORD_W-1:0] word;
    ref_latch_t        ref_q;
    ab_latch_t         ab_q;
    fn_latch_t         fn_q;

    cfg3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_le, ser_dat, ser_clk}),
        .q   (pins_sync)
    );

    assign {sle_s, sdat_s, sclk_s} = pins_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sle_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sle_d  <= sle_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = sle_s & ~sle_d;

    cfg3w_shifter #(.W(WORD_W)) i_shifter (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .din      (sdat_s),
        .word     (word)
    );

    cfg3w_latches i_latches (
        .clk   (clk),
        .rst   (rst),
        .load  (le_rise),
        .word  (word),
        .ref_q (ref_q),
        .ab_q  (ab_q),
        .fn_q  (fn_q)
    );

    assign ref_div     = ref_q.div;
    assign a_val       = ab_q.a;
    assign b_val       = ab_q.b;
    assign cp_boost    = ab_q.boost;
    assign mux_sel     = fn_q.mux_sel;
    assign pwr_down    = fn_q.pwr_down;
    assign fastlock_en = fn_q.fastlock_en;
    assign cnt_reset   = fn_q.cnt_reset;
    assign pd_polarity = fn_q.pd_polarity;

    AST_LE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> !le_rise); // R9
    AST_SCLK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise); // R2
endmodule

// File: tb/test_cfg3w_port.sv
module test_cfg3w_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_clk, ser_dat, ser_le;
    logic [13:0] ref_div;
    logic [4:0]  a_val;
    logic [12:0] b_val;
    logic        cp_boost;
    logic [2:0]  mux_sel;
    logic        pwr_down, fastlock_en, cnt_reset, pd_polarity;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    logic [13:0] e_ref;
    logic [4:0]  e_a;
    logic [12:0] e_b;
    logic        e_boost;
    logic [2:0]  e_mux;
    logic        e_pd, e_fl, e_cr, e_pol;

    always #4 clk = ~clk;

    cfg3w_port i_cfg3w_port (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_div(ref_div), .a_val(a_val), .b_val(b_val), .cp_boost(cp_boost),
        .mux_sel(mux_sel), .pwr_down(pwr_down), .fastlock_en(fastlock_en),
        .cnt_reset(cnt_reset), .pd_polarity(pd_polarity)
    );

    function automatic logic [40:0] act_state();
        return {ref_div, a_val, b_val, cp_boost, mux_sel, pwr_down, fastlock_en, cnt_reset, pd_polarity};
    endfunction

    function automatic logic [40:0] exp_state();
        return {e_ref, e_a, e_b, e_boost, e_mux, e_pd, e_fl, e_cr, e_pol};
    endfunction

    task automatic check(input string req);
        tests_run++;
        if (act_state() !== exp_state()) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", req, act_state(), exp_state());
        end
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = bits[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_le();
        @(negedge clk);
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [20:0] mk_ref(input logic [13:0] d);
        return {5'b10101, d, 2'b00};
    endfunction
    function automatic logic [20:0] mk_ab(input logic bst, input logic [12:0] b, input logic [4:0] a);
        return {bst, b, a, 2'b01};
    endfunction
    function automatic logic [20:0] mk_fn(input logic fl, input logic pol, input logic [2:0] m,
                                          input logic pd, input logic cr);
        return {12'hA5C, fl, pol, m, pd, cr, 2'b10};
    endfunction

    task automatic t_reset();
        check("R1 reset state");
    endtask

    task automatic t_ref(input logic [13:0] d, input string req);
        shift_bits(32'(mk_ref(d)), 21);
        check("R9 no change before latch enable");
        pulse_le();
        e_ref = d;
        check(req);
    endtask

    task automatic t_ab(input logic bst, input logic [12:0] b, input logic [4:0] a, input string req);
        shift_bits(32'(mk_ab(bst, b, a)), 21);
        pulse_le();
        e_boost = bst; e_b = b; e_a = a;
        check(req);
    endtask

    task automatic t_fn(input logic fl, input logic pol, input logic [2:0] m, input logic pd,
                        input logic cr, input string req);
        shift_bits(32'(mk_fn(fl, pol, m, pd, cr)), 21);
        pulse_le();
        e_fl = fl; e_pol = pol; e_mux = m; e_pd = pd; e_cr = cr;
        check(req);
    endtask

    task automatic t_reserved();
        shift_bits(32'h1FFFFF, 21);
        pulse_le();
        check("R7 reserved address ignored");
    endtask

    task automatic t_overlong();
        shift_bits({4'b1011, 7'd0, mk_ref(14'h1234)}, 25);
        pulse_le();
        e_ref = 14'h1234;
        check("R3 extra leading bits dropped");
    endtask

    task automatic t_latency();
        shift_bits(32'(mk_ref(14'h0F0F)), 21);
        @(negedge clk);
        ser_le = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 not yet after second edge");
        @(posedge clk);
        @(negedge clk);
        e_ref = 14'h0F0F;
        check("R10 loaded after third edge");
        repeat (20) @(negedge clk);
        check("R9 held latch enable loads once");
        shift_bits(32'(mk_ref(14'h0001)), 21);
        check("R9 shifting with latch enable high has no effect");
        ser_le = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 falling latch enable has no effect");
    endtask

    initial begin
        ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
        {e_ref, e_a, e_b, e_boost, e_mux, e_pd, e_fl, e_cr, e_pol} = '0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_ref(14'h2A5B, "R4 reference latch load, R8 others hold");
        t_ab(1'b1, 13'h0ABC, 5'h13, "R5 A/B latch load, R8 others hold");
        t_fn(1'b1, 1'b0, 3'b101, 1'b1, 1'b0, "R6 function latch load, R8 others hold");
        t_fn(1'b0, 1'b1, 3'b010, 1'b0, 1'b1, "R6 function latch second pattern");
        t_ab(1'b0, 13'h1FFF, 5'h1F, "R5 A/B extreme values");
        t_ref(14'h3FFF, "R4 reference maximum");
        t_ref(14'h0000, "R2 MSB-first order, reference zero");
        t_reserved();
        t_overlong();
        t_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog R9 run did not complete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule